// File: doc/BRIEF.md
# Cheat Cartridge Control Register Bank

This block is the control front end of a pass-through cheat cartridge that sits between a host and a downstream game cartridge. The host writes a bank of 32 sixteen-bit registers over a word-addressed write bus that carries separate strobes for the low and high byte lanes. Register 0 is the mode word. Each write to it decides where later host reads are served from: the cartridge's own ROM, the register bank itself, or the downstream cartridge.

Setting the lock bit in a mode write copies six patch address/data pairs from fixed places in the bank into working registers. Each pair is a 22-bit byte address and a 16-bit replacement word. The low six bits of the mode register give the per-slot enables. A combinational readback port returns any bank word so that the register view of the read path can be served. The comparison of host read addresses against the patches happens downstream, as does the ROM itself.

Top module: `cheat_ctl_bank`

## Requirements
- R1: While reset is asserted, and after it is released, every bank register, every latched patch address and word, the bypass flag and the register-view flag are zero.
- R2: A write updates bits 7:0 of the addressed register only when the low-lane strobe is high, and bits 15:8 only when the high-lane strobe is high. A write with both strobes high updates the whole word.
- R3: A write whose word offset is 0x20 or above has no effect on any register, flag or latched patch. This holds even when its low five bits alias a real register.
- R4: A write to offset 0 with data bit 10 set turns on bypass (`route_bypass`=1, reads go downstream). A write to offset 0 with bit 10 clear turns bypass off.
- R5: A write to offset 0 with bit 10 clear sets `route_regs` to data bit 9 (1 = register view, 0 = internal ROM). A write with bit 10 set leaves `route_regs` unchanged.
- R6: A write to offset 0 with data bit 8 set latches the address of slot s (s = 0..5) from base register b = 2+3s. The address is {reg[b][5:0], reg[b+1][15:0]} and appears on `patch_addr[22*s +: 22]`.
- R7: The same lock event latches the word of slot s from reg[b+2] onto `patch_data[16*s +: 16]`.
- R8: Without a lock event, the latched patch addresses and words hold their values even when the source registers change.
- R9: Every in-range write to offset 1 leaves bit 0 of register 1 at 1, whatever the strobes and data.
- R10: `patch_en` always equals bits 5:0 of register 0.
- R11: `rd_data` is the bank register indexed by the low five bits of `rd_ofs`, combinationally.
- R12: The mode decode (R4, R5) and the lock (R6, R7) take bits 10:8 from the incoming write data whenever a write to offset 0 occurs, even when the high-lane strobe is low and register 0's high byte does not change. All state changes on the rising clock edge of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_ofs | input | 8 | Word offset of the write |
| wr_lo | input | 1 | Low byte lane enable |
| wr_hi | input | 1 | High byte lane enable |
| wr_data | input | 16 | Write data word |
| rd_ofs | input | 8 | Word offset for register readback |
| rd_data | output | 16 | Bank word at rd_ofs[4:0] |
| route_bypass | output | 1 | Reads go to the downstream cartridge |
| route_regs | output | 1 | When not bypassed: 1 register view, 0 internal ROM |
| patch_en | output | 6 | Per-slot patch enables (register 0 bits 5:0) |
| patch_addr | output | 132 | Six latched 22-bit patch byte addresses, slot 0 lowest |
| patch_data | output | 96 | Six latched 16-bit replacement words, slot 0 lowest |

## Verification
The bench goes after a mode write made on the low lane alone with bit 10 set in the data word. A design that decoded the mode from the stored register would miss both the bypass change and the lock. It also writes to offsets 0x20 and 0x21. A design that compared only five offset bits would corrupt registers 0 and 1 and fire a spurious lock. Base registers are loaded with high bits above bit 5, which catches a design that fails to mask the upper address field. The bench rewrites the source registers after a lock, which exposes a patch that follows the bank instead of holding. A bypass write must leave the register-view flag alone, and a write to offset 1 with data bit 0 clear must still read back with bit 0 set.

// File: rtl/cheat_ctl_pkg.sv
package cheat_ctl_pkg;

  // Mode word bit positions (decoded from write data at offset MODE_OFS)
  localparam int unsigned MODE_BYPASS_BIT = 10;
  localparam int unsigned MODE_REGSEL_BIT = 9;
  localparam int unsigned MODE_LOCK_BIT   = 8;

  // Special register offsets
  localparam int unsigned MODE_OFS  = 0;
  localparam int unsigned FORCE_OFS = 1;

  typedef struct packed {
    logic bypass;
    logic regsel;
  } route_t;

endpackage

// File: rtl/cheat_ctl_rst_sync.sv
module cheat_ctl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_core_n = sync_q[STAGES-1];

endmodule

// File: rtl/cheat_ctl_regfile.sv
module cheat_ctl_regfile
  import cheat_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned HALF  = DATA_W / 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_hit,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic                    wr_lo,
  input  logic                    wr_hi,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [DATA_W-1:0]       rd_data,
  output logic [DEPTH*DATA_W-1:0] bank_flat
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    localparam bit IS_FORCE = (g == FORCE_OFS);

    logic              sel;
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] d;

    assign sel = wr_hit && (wr_idx == IDX_W'(g));

    always_comb begin
      d = q;
      if (wr_lo) begin
        d[HALF-1:0] = wr_data[HALF-1:0];
      end
      if (wr_hi) begin
        d[DATA_W-1:HALF] = wr_data[DATA_W-1:HALF];
      end
      if (IS_FORCE) begin
        d[0] = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (sel) begin
        q <= d;
      end
    end

    assign bank_flat[g*DATA_W +: DATA_W] = q;
  end

  assign rd_data = bank_flat[rd_idx*DATA_W +: DATA_W];

endmodule

// File: rtl/cheat_ctl_mode.sv
module cheat_ctl_mode
  import cheat_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [DATA_W-1:0] wr_data,
  output route_t            route,
  output logic              lock
);

  route_t route_q;
  route_t route_d;

  always_comb begin
    route_d = route_q;
    if (mode_wr) begin
      if (wr_data[MODE_BYPASS_BIT]) begin
        route_d.bypass = 1'b1;
      end else begin
        route_d.bypass = 1'b0;
        route_d.regsel = wr_data[MODE_REGSEL_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
    end else if (mode_wr) begin
      route_q <= route_d;
    end
  end

  assign route = route_q;
  assign lock  = mode_wr && wr_data[MODE_LOCK_BIT];

endmodule

// File: rtl/cheat_ctl_patch.sv
module cheat_ctl_patch #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned HI_W       = 6,
  parameter int unsigned DEPTH      = 32,
  parameter int unsigned NUM_SLOTS  = 6,
  parameter int unsigned FIRST_BASE = 2,
  parameter int unsigned STRIDE     = 3,
  localparam int unsigned PA_W      = HI_W + DATA_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        lock,
  input  logic [DEPTH*DATA_W-1:0]     bank_flat,
  output logic [NUM_SLOTS*PA_W-1:0]   patch_addr,
  output logic [NUM_SLOTS*DATA_W-1:0] patch_data
);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam int unsigned BASE = FIRST_BASE + STRIDE * s;

    logic [PA_W-1:0]   addr_q, addr_d;
    logic [DATA_W-1:0] data_q, data_d;

    always_comb begin
      addr_d = addr_q;
      data_d = data_q;
      if (lock) begin
        addr_d = {bank_flat[BASE*DATA_W +: HI_W],
                  bank_flat[(BASE+1)*DATA_W +: DATA_W]};
        data_d = bank_flat[(BASE+2)*DATA_W +: DATA_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q <= '0;
        data_q <= '0;
      end else if (lock) begin
        addr_q <= addr_d;
        data_q <= data_d;
      end
    end

    assign patch_addr[s*PA_W +: PA_W]     = addr_q;
    assign patch_data[s*DATA_W +: DATA_W] = data_q;
  end

endmodule

// File: rtl/cheat_ctl_bank.sv
module cheat_ctl_bank
  import cheat_ctl_pkg::*;
#(
  parameter int unsigned OFS_W      = 8,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned DEPTH      = 32,
  parameter int unsigned HI_W       = 6,
  parameter int unsigned NUM_SLOTS  = 6,
  parameter int unsigned FIRST_BASE = 2,
  parameter int unsigned STRIDE     = 3,
  localparam int unsigned IDX_W     = $clog2(DEPTH),
  localparam int unsigned PA_W      = HI_W + DATA_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [OFS_W-1:0]            wr_ofs,
  input  logic                        wr_lo,
  input  logic                        wr_hi,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [OFS_W-1:0]            rd_ofs,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        route_bypass,
  output logic                        route_regs,
  output logic [NUM_SLOTS-1:0]        patch_en,
  output logic [NUM_SLOTS*PA_W-1:0]   patch_addr,
  output logic [NUM_SLOTS*DATA_W-1:0] patch_data
);

  logic                    rst_core_n;
  logic                    wr_hit;
  logic [IDX_W-1:0]        wr_idx;
  logic                    mode_wr;
  logic                    lock;
  route_t                  route;
  logic [DEPTH*DATA_W-1:0] bank_flat;

  cheat_ctl_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  // Address decode: anything at or above DEPTH is dropped entirely
  assign wr_idx  = wr_ofs[IDX_W-1:0];
  assign wr_hit  = wr_en && ((wr_ofs >> IDX_W) == '0);
  assign mode_wr = wr_hit && (wr_idx == IDX_W'(MODE_OFS));

  cheat_ctl_regfile #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_hit    (wr_hit),
    .wr_idx    (wr_idx),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .wr_data   (wr_data),
    .rd_idx    (rd_ofs[IDX_W-1:0]),
    .rd_data   (rd_data),
    .bank_flat (bank_flat)
  );

  cheat_ctl_mode #(.DATA_W(DATA_W)) u_mode (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .mode_wr (mode_wr),
    .wr_data (wr_data),
    .route   (route),
    .lock    (lock)
  );

  cheat_ctl_patch #(
    .DATA_W     (DATA_W),
    .HI_W       (HI_W),
    .DEPTH      (DEPTH),
    .NUM_SLOTS  (NUM_SLOTS),
    .FIRST_BASE (FIRST_BASE),
    .STRIDE     (STRIDE)
  ) u_patch (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .lock       (lock),
    .bank_flat  (bank_flat),
    .patch_addr (patch_addr),
    .patch_data (patch_data)
  );

  assign route_bypass = route.bypass;
  assign route_regs   = route.regsel;
  assign patch_en     = bank_flat[MODE_OFS*DATA_W +: NUM_SLOTS];

endmodule

// File: rtl/cheat_ctl_bank_chk.sv
module cheat_ctl_bank_chk #(
  parameter int unsigned OFS_W     = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned DEPTH     = 32,
  parameter int unsigned NUM_SLOTS = 6,
  parameter int unsigned PA_W      = 22
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic [OFS_W-1:0]            wr_ofs,
  input logic [DATA_W-1:0]           wr_data,
  input logic [OFS_W-1:0]            rd_ofs,
  input logic [DATA_W-1:0]           rd_data,
  input logic                        route_bypass,
  input logic                        route_regs,
  input logic [NUM_SLOTS-1:0]        patch_en,
  input logic [NUM_SLOTS*PA_W-1:0]   patch_addr,
  input logic [NUM_SLOTS*DATA_W-1:0] patch_data
);

  logic in_range;
  logic mode_wr;
  assign in_range = (int'(wr_ofs) < DEPTH);
  assign mode_wr  = wr_en && (wr_ofs == '0);

  // R3: out-of-range writes change nothing observable
  a_r3_high_ofs_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_range) |=> ($stable(route_bypass) && $stable(route_regs) &&
                              $stable(patch_en) && $stable(patch_addr) &&
                              $stable(patch_data)));

  // R4: bit 10 of a mode write turns bypass on
  a_r4_bypass_on: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && wr_data[10]) |=> route_bypass);

  // R5: bit 10 clear -> bypass off and register view follows bit 9
  a_r5_regsel_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !wr_data[10]) |=> (!route_bypass && (route_regs == $past(wr_data[9]))));

  // R5: bit 10 set leaves register view as it was
  a_r5_regsel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && wr_data[10]) |=> $stable(route_regs));

  // R8: no lock, no change of latched patches
  a_r8_patch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_wr && wr_data[8]) |=> ($stable(patch_addr) && $stable(patch_data)));

  // R10: enables track the low bits of register 0 as seen through readback
  a_r10_en_matches_reg0: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ofs[4:0] == 5'd0) |-> (rd_data[NUM_SLOTS-1:0] == patch_en));

endmodule

bind cheat_ctl_bank cheat_ctl_bank_chk #(
  .OFS_W     (OFS_W),
  .DATA_W    (DATA_W),
  .DEPTH     (DEPTH),
  .NUM_SLOTS (NUM_SLOTS),
  .PA_W      (PA_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_ofs       (wr_ofs),
  .wr_data      (wr_data),
  .rd_ofs       (rd_ofs),
  .rd_data      (rd_data),
  .route_bypass (route_bypass),
  .route_regs   (route_regs),
  .patch_en     (patch_en),
  .patch_addr   (patch_addr),
  .patch_data   (patch_data)
);

// File: tb/sim_cheat_ctl_bank.sv
module sim_cheat_ctl_bank;

  logic         clk;
  logic         rst_n;
  logic         wr_en;
  logic [7:0]   wr_ofs;
  logic         wr_lo;
  logic         wr_hi;
  logic [15:0]  wr_data;
  logic [7:0]   rd_ofs;
  logic [15:0]  rd_data;
  logic         route_bypass;
  logic         route_regs;
  logic [5:0]   patch_en;
  logic [131:0] patch_addr;
  logic [95:0]  patch_data;

  cheat_ctl_bank u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ofs(wr_ofs),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .rd_ofs(rd_ofs),
    .rd_data(rd_data), .route_bypass(route_bypass), .route_regs(route_regs),
    .patch_en(patch_en), .patch_addr(patch_addr), .patch_data(patch_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Reference model
  logic [15:0] m_bank [32];
  logic        m_byp, m_reg;
  logic [21:0] m_addr [6];
  logic [15:0] m_dat  [6];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_bank[i] = '0;
    for (int s = 0; s < 6; s++) begin m_addr[s] = '0; m_dat[s] = '0; end
    m_byp = 1'b0; m_reg = 1'b0;
  endtask

  task automatic model_write(input logic [7:0] o, input bit lo, input bit hi,
                             input logic [15:0] d);
    if (o >= 8'd32) return;
    if (lo) m_bank[o[4:0]][7:0]  = d[7:0];
    if (hi) m_bank[o[4:0]][15:8] = d[15:8];
    if (o == 8'd1) m_bank[1][0] = 1'b1;
    if (o == 8'd0) begin
      if (d[10]) m_byp = 1'b1;
      else begin m_byp = 1'b0; m_reg = d[9]; end
      if (d[8]) begin
        for (int s = 0; s < 6; s++) begin
          m_addr[s] = {m_bank[2+3*s][5:0], m_bank[3+3*s]};
          m_dat[s]  = m_bank[4+3*s];
        end
      end
    end
  endtask

  task automatic do_write(input logic [7:0] o, input bit lo, input bit hi,
                          input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_ofs = o; wr_lo = lo; wr_hi = hi; wr_data = d;
    model_write(o, lo, hi, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_rd(input logic [7:0] o, input string req);
    rd_ofs = o;
    #1;
    chk(rd_data === m_bank[o[4:0]], req, {16'h0, rd_data}, {16'h0, m_bank[o[4:0]]});
  endtask

  task automatic check_outs(input string req);
    chk(route_bypass === m_byp, {req, " bypass"}, {31'h0, route_bypass}, {31'h0, m_byp});
    chk(route_regs === m_reg, {req, " regsel"}, {31'h0, route_regs}, {31'h0, m_reg});
    chk(patch_en === m_bank[0][5:0], {req, " R10 enables"}, {26'h0, patch_en},
        {26'h0, m_bank[0][5:0]});
    for (int s = 0; s < 6; s++) begin
      chk(patch_addr[s*22 +: 22] === m_addr[s], {req, " R6 addr"},
          {10'h0, patch_addr[s*22 +: 22]}, {10'h0, m_addr[s]});
      chk(patch_data[s*16 +: 16] === m_dat[s], {req, " R7 data"},
          {16'h0, patch_data[s*16 +: 16]}, {16'h0, m_dat[s]});
    end
  endtask

  task automatic check_all_rd(input string req);
    for (int i = 0; i < 32; i++) check_rd(8'(i), req);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    check_outs("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 1'b0; wr_ofs = '0; wr_lo = 1'b0; wr_hi = 1'b0;
    wr_data = '0; rd_ofs = '0;
    model_reset();
    apply_reset();
    check_outs("R1 after release");
    check_all_rd("R1 bank cleared");

    // R2: separate lanes
    do_write(8'd3, 1'b1, 1'b0, 16'h12AB);
    check_rd(8'd3, "R2 low lane only");
    do_write(8'd3, 1'b0, 1'b1, 16'hCD34);
    check_rd(8'd3, "R2 high lane only");

    // R9: bit 0 of register 1 forced
    do_write(8'd1, 1'b1, 1'b1, 16'h5A00);
    check_rd(8'd1, "R9 force bit0");
    do_write(8'd1, 1'b1, 1'b0, 16'h0000);
    check_rd(8'd1, "R9 force bit0 low lane");

    // Load slot sources with high bits above bit 5 to test masking (R6)
    for (int s = 0; s < 6; s++) begin
      do_write(8'(2 + 3*s), 1'b1, 1'b1, 16'hFFC0 | 16'(s * 7 + 3));
      do_write(8'(3 + 3*s), 1'b1, 1'b1, 16'h1111 * 16'(s + 1));
      do_write(8'(4 + 3*s), 1'b1, 1'b1, 16'hA5A5 ^ 16'(s << 4));
    end
    check_outs("R8 before lock");

    // Lock with all enables, ROM view
    do_write(8'd0, 1'b1, 1'b1, 16'h013F);
    check_outs("R6 R7 lock");

    // R8: change sources, no lock; also R5 register view
    do_write(8'd3, 1'b1, 1'b1, 16'hBEEF);
    do_write(8'd4, 1'b1, 1'b1, 16'h0F0F);
    do_write(8'd0, 1'b1, 1'b1, 16'h0215);
    check_outs("R8 R5 no lock regsel");

    // R4 and R5 hold under bypass
    do_write(8'd0, 1'b1, 1'b1, 16'h0400);
    check_outs("R4 R5 bypass keeps regsel");
    do_write(8'd0, 1'b1, 1'b1, 16'h0000);
    check_outs("R4 bypass off");

    // R12: low-lane-only mode write with bit10 and bit8 in the data word
    do_write(8'd0, 1'b1, 1'b0, 16'h0522);
    check_outs("R12 low-lane mode write");
    check_rd(8'd0, "R12 reg0 high byte unchanged");

    // R3: out-of-range writes aliasing registers 0 and 1
    do_write(8'd32, 1'b1, 1'b1, 16'h0300);
    do_write(8'd33, 1'b1, 1'b1, 16'hFFFE);
    do_write(8'd255, 1'b1, 1'b1, 16'h0100);
    check_outs("R3 out of range");
    check_all_rd("R3 bank untouched");

    // R11: readback alias through low five bits
    check_rd(8'h43, "R11 alias 0x43");
    check_rd(8'hFF, "R11 alias 0xFF");

    // Random traffic
    for (int n = 0; n < 400; n++) begin
      logic [7:0]  o;
      logic [15:0] d;
      o = ($urandom_range(0, 3) == 0) ? 8'd0 : 8'($urandom_range(0, 47));
      d = 16'($urandom);
      do_write(o, 1'($urandom), 1'($urandom), d);
      check_outs("R2 R4 R5 R6 R7 random");
      check_rd(8'($urandom), "R11 random readback");
    end

    // R1: reset again from a busy state
    apply_reset();
    check_outs("R1 second reset");
    check_all_rd("R1 second reset bank");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule